// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This block turns a 6-bit operand specifier into an operand location for a 16-bit machine with eight general registers. The specifier has a 3-bit mode and a 3-bit register number. The block reads the register file and updates it when a mode asks for that. It fetches an extension word from the instruction stream when needed, and it follows one level of memory indirection. When it finishes, it reports one of two results: the operand is a register (and which one), or the operand sits at a final memory address.

A specifier enters on a valid/ready request port. `req_ready` is high only while the sequencer is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. The requester must hold `req_valid`, `req_mode`, `req_reg` and `req_byte` steady until that cycle. After it accepts a request, the block drops `req_ready` until its `done` pulse has passed, so back-pressure lasts for the whole resolution.

The register file is outside the block and has a combinational read port and a clocked write port. Memory reads use a request/acknowledge pair:
- `mem_req` stays high with a stable `mem_addr` until `mem_ack` arrives.
- `mem_rdata` is taken in the acknowledge cycle.
- The acknowledge may come in the same cycle as the request or any number of cycles later.

The top register (index 7) is the program counter. On entry it is assumed to already point just past the instruction word.

Top module: `ea_sequencer`

## Requirements
- R1: After reset `req_ready` is 1, and `done`, `mem_req` and `rf_we` are 0. `req_ready` is 1 only when idle. It drops in the cycle after a request is accepted and stays 0 until `done` has been issued.
- R2: Mode 0 reports `res_is_reg`=1 with `res_reg` equal to the requested register. It performs no register write and no memory read.
- R3: Mode 1 reports the register contents as the address. It performs no register write and no memory read.
- R4: Mode 2 reports the register contents as the address, then adds the step to the register. Mode 3 reads the word at the register contents and reports it as the address, then adds 2 to the register.
- R5: Mode 4 subtracts the step from the register and reports the new value as the address. Mode 5 subtracts 2 and reports the word read at the new value.
- R6: Modes 6 and 7 work as follows:
  - Read the extension word at the program counter, then add 2 to the program counter.
  - Form the sum of the register (read after that update) and the extension word.
  - Mode 6 reports the sum as the address. Mode 7 reports the word read at the sum.
- R7: The step for modes 2 and 4 is 1 when the access is a byte access (`req_byte`=1) and the register index is below 6. It is 2 otherwise. The deferred modes 3 and 5 always step by 2.
- R8: With register 7 the same modes work as follows:
  - Mode 2 yields the address of the word after the instruction (immediate).
  - Mode 3 yields the address held in that word (absolute).
  - Mode 6 yields instruction address + 4 + extension word (relative).
  - Mode 7 yields the word read at that relative address.
- R9: `res_odd` is 1 with `done` exactly when the result is a memory address, the access is a word access, and address bit 0 is 1. It is never set for a register result or a byte access.
- R10: `mem_req` stays high with an unchanged `mem_addr` until `mem_ack`. The number of reads is 0 for modes 0, 1, 2 and 4, 1 for modes 3, 5 and 6, and 2 for mode 7.
- R11: `done` is a one-cycle pulse, and `res_is_reg`, `res_reg`, `res_addr` and `res_odd` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Specifier request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_mode | input | 3 | Addressing mode |
| req_reg | input | 3 | Register number |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 16 | Memory read data |
| done | output | 1 | Result pulse |
| res_is_reg | output | 1 | Operand is a register |
| res_reg | output | 3 | Register number of the operand |
| res_addr | output | 16 | Final operand memory address |
| res_odd | output | 1 | Word access to an odd address |

## Verification
The embedded assertions check several properties on every cycle:
- the memory request holds with a steady address until acknowledged;
- `done` lasts one cycle;
- acceptance drops `req_ready`;
- every register write moves the value by exactly one or two;
- a register result never flags an odd address and follows a cycle with no register write.

Only the bench scenarios can show that each mode yields the right address and the right final register contents, that the extension word is added to the program counter after its update, and that the read count per mode is correct. The bench compares these against a shadow register file and memory function, under acknowledge latencies of zero to two cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_EXT,
    ST_IDX,
    ST_IND,
    ST_DONE
  } ea_state_e;

  localparam logic [2:0] MD_REG     = 3'd0;
  localparam logic [2:0] MD_REG_DEF = 3'd1;
  localparam logic [2:0] MD_INC     = 3'd2;
  localparam logic [2:0] MD_INC_DEF = 3'd3;
  localparam logic [2:0] MD_DEC     = 3'd4;
  localparam logic [2:0] MD_DEC_DEF = 3'd5;
  localparam logic [2:0] MD_IDX     = 3'd6;
  localparam logic [2:0] MD_IDX_DEF = 3'd7;
endpackage

// File: rtl/ea_adjust.sv
module ea_adjust #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic [DW-1:0] val,
  input  logic [RW-1:0] reg_idx,
  input  logic          byte_op,
  input  logic          defer,
  input  logic          dec,
  output logic [DW-1:0] res
);
  localparam logic [RW-1:0] FIRST_WIDE = RW'(NREG - 2);

  logic          small_step;
  logic [DW-1:0] step;

  always_comb begin
    small_step = byte_op && !defer && (reg_idx < FIRST_WIDE);
    step       = small_step ? DW'(1) : DW'(2);
    res        = dec ? (val - step) : (val + step);
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_mode,
  input  logic [RW-1:0] req_reg,
  input  logic          req_byte,
  output logic [RW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          adj_dec,
  output logic          adj_defer,
  output logic          adj_byte,
  output logic [RW-1:0] adj_reg,
  input  logic [DW-1:0] adj_res,
  output logic          done,
  output logic          res_is_reg,
  output logic [RW-1:0] res_reg,
  output logic [DW-1:0] res_addr,
  output logic          res_odd
);
  localparam logic [RW-1:0] PC_IDX = RW'(NREG - 1);

  ea_state_e     state_q, state_n;
  logic [2:0]    mode_q;
  logic [RW-1:0] reg_q;
  logic          byte_q;
  logic          isreg_q, isreg_n;
  logic [DW-1:0] ptr_q, ptr_n;
  logic [DW-1:0] ext_q, ext_n;
  logic [DW-1:0] idx_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      reg_q   <= '0;
      byte_q  <= 1'b0;
      isreg_q <= 1'b0;
      ptr_q   <= '0;
      ext_q   <= '0;
    end else begin
      state_q <= state_n;
      isreg_q <= isreg_n;
      ptr_q   <= ptr_n;
      ext_q   <= ext_n;
      if (req_valid && req_ready) begin
        mode_q <= req_mode;
        reg_q  <= req_reg;
        byte_q <= req_byte;
      end
    end
  end

  assign idx_sum   = rf_rdata + ext_q;
  assign adj_dec   = (state_q == ST_BASE) && mode_q[2] && !mode_q[1];
  assign adj_defer = mode_q[0];
  assign adj_byte  = byte_q;
  assign adj_reg   = rf_raddr;

  always_comb begin
    state_n   = state_q;
    isreg_n   = isreg_q;
    ptr_n     = ptr_q;
    ext_n     = ext_q;
    req_ready = 1'b0;
    rf_raddr  = reg_q;
    rf_we     = 1'b0;
    rf_waddr  = reg_q;
    rf_wdata  = adj_res;
    mem_req   = 1'b0;
    mem_addr  = ptr_q;
    done      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          state_n = ST_BASE;
          isreg_n = 1'b0;
        end
      end
      ST_BASE: begin
        unique case (mode_q)
          MD_REG: begin
            isreg_n = 1'b1;
            state_n = ST_DONE;
          end
          MD_REG_DEF: begin
            ptr_n   = rf_rdata;
            state_n = ST_DONE;
          end
          MD_INC, MD_INC_DEF: begin
            rf_we   = 1'b1;
            ptr_n   = rf_rdata;
            state_n = mode_q[0] ? ST_IND : ST_DONE;
          end
          MD_DEC, MD_DEC_DEF: begin
            rf_we   = 1'b1;
            ptr_n   = adj_res;
            state_n = mode_q[0] ? ST_IND : ST_DONE;
          end
          default: state_n = ST_EXT;
        endcase
      end
      ST_EXT: begin
        rf_raddr = PC_IDX;
        rf_waddr = PC_IDX;
        mem_req  = 1'b1;
        mem_addr = rf_rdata;
        if (mem_ack) begin
          ext_n   = mem_rdata;
          rf_we   = 1'b1;
          state_n = ST_IDX;
        end
      end
      ST_IDX: begin
        ptr_n   = idx_sum;
        state_n = mode_q[0] ? ST_IND : ST_DONE;
      end
      ST_IND: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          ptr_n   = mem_rdata;
          state_n = ST_DONE;
        end
      end
      ST_DONE: begin
        done    = 1'b1;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  assign res_is_reg = isreg_q;
  assign res_reg    = reg_q;
  assign res_addr   = ptr_q;
  assign res_odd    = done && !isreg_q && !byte_q && ptr_q[0];

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R7
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (DW'(rf_wdata - rf_rdata) == DW'(1) || DW'(rf_wdata - rf_rdata) == DW'(2) ||
               DW'(rf_rdata - rf_wdata) == DW'(1) || DW'(rf_rdata - rf_wdata) == DW'(2)));

  // R9
  reg_not_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_is_reg |-> !res_odd);

  // R2
  reg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_is_reg |-> $past(!rf_we && !mem_req));
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_mode,
  input  logic [RW-1:0] req_reg,
  input  logic          req_byte,
  output logic [RW-1:0] rf_raddr,
  input  logic [DW-1:0] rf_rdata,
  output logic          rf_we,
  output logic [RW-1:0] rf_waddr,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          res_is_reg,
  output logic [RW-1:0] res_reg,
  output logic [DW-1:0] res_addr,
  output logic          res_odd
);
  logic          adj_dec;
  logic          adj_defer;
  logic          adj_byte;
  logic [RW-1:0] adj_reg;
  logic [DW-1:0] adj_res;

  ea_adjust #(.DW(DW), .NREG(NREG)) u_adjust (
    .val     (rf_rdata),
    .reg_idx (adj_reg),
    .byte_op (adj_byte),
    .defer   (adj_defer),
    .dec     (adj_dec),
    .res     (adj_res)
  );

  ea_ctrl #(.DW(DW), .NREG(NREG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_mode   (req_mode),
    .req_reg    (req_reg),
    .req_byte   (req_byte),
    .rf_raddr   (rf_raddr),
    .rf_rdata   (rf_rdata),
    .rf_we      (rf_we),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .adj_dec    (adj_dec),
    .adj_defer  (adj_defer),
    .adj_byte   (adj_byte),
    .adj_reg    (adj_reg),
    .adj_res    (adj_res),
    .done       (done),
    .res_is_reg (res_is_reg),
    .res_reg    (res_reg),
    .res_addr   (res_addr),
    .res_odd    (res_odd)
  );
endmodule

// File: tb/ea_sequencer_tb.sv
module ea_sequencer_tb;
  typedef struct {
    logic [2:0]  mode;
    logic [2:0]  rn;
    logic        bop;
    logic        isreg;
    logic [15:0] addr;
    logic        odd;
    int          reads;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic [2:0]  req_reg = '0;
  logic        req_byte = 1'b0;
  logic [2:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata;
  logic        done;
  logic        res_is_reg;
  logic [2:0]  res_reg;
  logic [15:0] res_addr;
  logic        res_odd;

  logic [15:0] regs [8];
  logic [15:0] exp_regs [8];
  item_t       sb [$];
  int          checks = 0;
  int          errors = 0;
  int          rd_cnt = 0;
  int          mem_wait = 0;
  int          wcnt = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return (a ^ 16'h5A5A) + 16'h0100;
  endfunction

  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = memf(mem_addr);

  ea_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_reg(req_reg), .req_byte(req_byte),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .res_is_reg(res_is_reg), .res_reg(res_reg),
    .res_addr(res_addr), .res_odd(res_odd)
  );

  always @(posedge clk) begin
    if (rf_we) regs[rf_waddr] <= rf_wdata;
    if (mem_req && mem_ack) rd_cnt <= rd_cnt + 1;
  end

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= mem_wait) mem_ack = 1'b1;
      else wcnt++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each done pulse with the queued expectation
  always @(negedge clk) begin
    if (done && !finished) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11", "unexpected done", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(res_is_reg == it.isreg, it.tag, "is_reg", 32'(res_is_reg), 32'(it.isreg));
        if (it.isreg)
          check(res_reg == it.rn, "R2", "reg number", 32'(res_reg), 32'(it.rn));
        else
          check(res_addr == it.addr, it.tag, "address", 32'(res_addr), 32'(it.addr));
        check(res_odd == it.odd, "R9", "odd flag", 32'(res_odd), 32'(it.odd));
        check(rd_cnt == it.reads, "R10", "read count", 32'(rd_cnt), 32'(it.reads));
        for (int i = 0; i < 8; i++)
          check(regs[i] == exp_regs[i], "R7", $sformatf("reg %0d after update", i),
                32'(regs[i]), 32'(exp_regs[i]));
      end
    end
  end

  task automatic run(input logic [2:0] m, input logic [2:0] r, input logic b, input int lat);
    item_t it;
    logic [15:0] st;
    logic [15:0] x;
    st = (b && r < 3'd6) ? 16'd1 : 16'd2;
    it.mode = m; it.rn = r; it.bop = b; it.isreg = 1'b0; it.addr = '0; it.reads = 0;
    case (m)
      3'd0: begin it.isreg = 1'b1; it.tag = "R2"; end
      3'd1: begin it.addr = exp_regs[r]; it.tag = "R3"; end
      3'd2: begin it.addr = exp_regs[r]; exp_regs[r] += st; it.tag = "R4"; end
      3'd3: begin it.addr = memf(exp_regs[r]); exp_regs[r] += 16'd2; it.reads = 1; it.tag = "R4"; end
      3'd4: begin exp_regs[r] -= st; it.addr = exp_regs[r]; it.tag = "R5"; end
      3'd5: begin exp_regs[r] -= 16'd2; it.addr = memf(exp_regs[r]); it.reads = 1; it.tag = "R5"; end
      default: begin
        x = memf(exp_regs[7]);
        exp_regs[7] += 16'd2;
        it.addr  = exp_regs[r] + x;
        it.reads = 1;
        if (m == 3'd7) begin it.addr = memf(it.addr); it.reads = 2; end
        it.tag = "R6";
      end
    endcase
    if (r == 3'd7 && m != 3'd0 && m != 3'd1) it.tag = "R8";
    it.odd = !it.isreg && !b && it.addr[0];
    sb.push_back(it);
    @(negedge clk);
    mem_wait = lat;
    rd_cnt = 0;
    req_mode = m; req_reg = r; req_byte = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1", "ready while busy", 32'(req_ready), 32'd0);
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R11", "done pulse width", 32'(done), 32'd0);
    check(req_ready == 1'b1, "R1", "ready after done", 32'(req_ready), 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      regs[i] = 16'h1000 + 16'(i * 16'h0111);
      exp_regs[i] = regs[i];
    end
    regs[1] = 16'h2001; exp_regs[1] = 16'h2001;
    regs[7] = 16'h0400; exp_regs[7] = 16'h0400;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 32'd1);
    check(done == 1'b0 && mem_req == 1'b0 && rf_we == 1'b0, "R1", "reset idle outputs",
          32'({done, mem_req, rf_we}), 32'd0);
    begin
      int n;
      n = 0;
      for (int m = 0; m < 8; m++) begin
        for (int k = 0; k < 4; k++) begin
          for (int b = 0; b < 2; b++) begin
            logic [2:0] r;
            r = (k == 0) ? 3'd1 : (k == 1) ? 3'd3 : (k == 2) ? 3'd6 : 3'd7;
            run(3'(m), r, 1'(b), n % 3);
            n++;
          end
        end
      end
    end
    // R9: odd register with word access flags, byte access does not
    run(3'd1, 3'd1, 1'b0, 0);
    run(3'd1, 3'd1, 1'b1, 1);
    // R7: byte autoincrement on low register steps by one, deferred by two
    run(3'd2, 3'd0, 1'b1, 0);
    run(3'd3, 3'd0, 1'b1, 2);
    run(3'd4, 3'd2, 1'b1, 0);
    run(3'd5, 3'd2, 1'b1, 1);
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R11", "pending results", 32'(sb.size()), 32'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R11 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule